// File: doc/BRIEF.md
# Dual-Class Interrupt Controller Core

This block gathers a set of level-sensitive interrupt lines into two 32-bit register banks. Sources 0 to 31 live in bank 0 and the remaining sources live in the low bits of bank 1. Each source has three state bits: a pending bit, an enable bit and a class bit. The pending bit follows the line level, the enable bit is set by software, and the class bit steers the source to either the fast-interrupt output (`fiq_o`) or the normal-interrupt output (`irq_o`). A sleeping core receives a wake request (`wake_o`). A control bit decides whether that request counts only enabled sources or every pending source.

Software reaches the block through a plain 32-bit register port with one write strobe and a combinational read data bus. A priority table holds one entry per source. Each entry is a valid flag plus a source id. A resolver scans the table from entry 0 upward and reports, in one word, the first active normal source and the first active fast source it finds. The register port and the source lines are control pins with no flow control. Every write is accepted in the cycle it is presented, and a read returns data in the same cycle.

Top module: `dual_class_intc`

## Requirements
- R1: The raw-pending bits (offset 0x10 for bank 0, 0xAC for bank 1) equal the source levels sampled at the previous clock edge. There is no latching: a bit clears as soon as its line falls.
- R2: Source n sits in bank n/32 at bit n%32. Bank-1 registers sit at 0x9C (normal view), 0xA0 (enable), 0xA4 (class), 0xA8 (fast view) and 0xAC (raw). Bank-1 bits above the last source always read 0.
- R3: `fiq_o` is registered. In the cycle after the inputs or a write, it is 1 exactly when some source is pending, enabled and has class bit 1.
- R4: `irq_o` is registered. In the cycle after the inputs or a write, it is 1 exactly when some source is pending, enabled and has class bit 0.
- R5: Bank-0 registers: 0x04 enable and 0x08 class, both read/write; class bit 1 selects the fast output. 0x00 reads pending AND enable AND NOT class. 0x0C reads pending AND enable AND class.
- R6: The control register is at 0x14. A write takes bit 0 and reads back as 0 or 1. A value of 1 restricts waking to enabled sources; a value of 0 lets any pending source wake the core.
- R7: `wake_o` is registered. It is 1 in the cycle after `core_idle_i` was high and some source was pending and either enabled or admitted by control value 0.
- R8: Priority entries 0..31 sit at 0x1C + 4*i and entries 32..39 at 0xB0 + 4*(i-32). A write keeps only bit 31 (valid) and bits 5:0 (source id). All other bits read back as 0.
- R9: Offset 0x18 reads the resolver word. Bit 31 flags a normal hit and bits 21:16 hold its id. Bit 15 flags a fast hit and bits 5:0 hold its id. All other bits are 0, and a missing hit reads id 0x3F with its flag at 0 (0x003F003F when neither class hits). The lowest-numbered entry whose valid bit is set, whose id is below 40 and whose source is active in that class wins.
- R10: After reset, pending, enable, class and every priority entry are zero, the control bit is 0, and all three outputs are low.
- R11: A write to a misaligned, unmapped or read-only offset (0x00, 0x0C, 0x10, 0x18 and their bank-1 peers) changes no state. A read of an unmapped or misaligned offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl_i | input | NUM_SRC | Live interrupt line levels |
| core_idle_i | input | 1 | High while the core is idle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on the offset |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake request to an idle core |

## Verification
The bench builds the block with the default NUM_SRC of 40. This fills bank 0 completely and leaves bank 1 partly used, so the zero upper bits of bank 1, the split priority window ending at 0xCC, and the unmapped offset 0xD0 just past it can all be reached. Priority ids from 40 to 63 fit in the 6-bit field but name no source. Because of this, the rule that such entries are skipped can be tested alongside the rule that the lowest entry wins.

// File: rtl/dcic_pkg.sv
package dcic_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 8;
  localparam int ID_W   = 6;
  localparam int NBANK  = 2;

  // byte offsets of the register window
  localparam logic [ADDR_W-1:0] OFS_RAW     = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_HIGH    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_PRIO_LO = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_PRIO_LE = 8'h98;
  localparam logic [ADDR_W-1:0] OFS_BANK1   = 8'h9C;
  localparam logic [ADDR_W-1:0] OFS_PRIO_HI = 8'hB0;

  // word index inside a bank window; order fixed by the offset map
  typedef enum logic [2:0] {
    V_NORM = 3'd0,
    V_EN   = 3'd1,
    V_CLS  = 3'd2,
    V_FAST = 3'd3,
    V_RAW  = 3'd4
  } bank_view_e;

  typedef struct packed {
    logic            vld;
    logic [ID_W-1:0] id;
  } prio_ent_t;
endpackage

// File: rtl/dcic_src_state.sv
module dcic_src_state #(
  parameter int NUM_SRC = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SRC-1:0]     src_lvl_i,
  input  logic                   core_idle_i,
  input  logic [dcic_pkg::NBANK-1:0] en_we_i,
  input  logic [dcic_pkg::NBANK-1:0] cls_we_i,
  input  logic                   ctrl_we_i,
  input  logic [dcic_pkg::WORD_W-1:0] wdata_i,
  output logic [NUM_SRC-1:0]     pend_q,
  output logic [NUM_SRC-1:0]     en_q,
  output logic [NUM_SRC-1:0]     cls_q,
  output logic                   ctrl_q,
  output logic                   irq_o,
  output logic                   fiq_o,
  output logic                   wake_o
);
  import dcic_pkg::*;

  logic [NUM_SRC-1:0] en_d, cls_d, wake_admit;
  logic               ctrl_d;
  logic               past_ok;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      en_d[i]  = en_we_i[i / WORD_W]  ? wdata_i[i % WORD_W] : en_q[i];
      cls_d[i] = cls_we_i[i / WORD_W] ? wdata_i[i % WORD_W] : cls_q[i];
    end
    ctrl_d     = ctrl_we_i ? wdata_i[0] : ctrl_q;
    wake_admit = en_d | {NUM_SRC{~ctrl_d}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      en_q    <= '0;
      cls_q   <= '0;
      ctrl_q  <= 1'b0;
      irq_o   <= 1'b0;
      fiq_o   <= 1'b0;
      wake_o  <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      pend_q  <= src_lvl_i;
      en_q    <= en_d;
      cls_q   <= cls_d;
      ctrl_q  <= ctrl_d;
      irq_o   <= |(src_lvl_i & en_d & ~cls_d);
      fiq_o   <= |(src_lvl_i & en_d & cls_d);
      wake_o  <= core_idle_i & (|(src_lvl_i & wake_admit));
      past_ok <= 1'b1;
    end
  end

  // R1
  pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    pend_q == $past(src_lvl_i));

  // R7
  wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    wake_o |-> $past(core_idle_i));
endmodule

// File: rtl/dcic_prio_table.sv
module dcic_prio_table #(
  parameter int NUM_SRC = 40,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_i,
  input  logic [IDX_W-1:0]                    idx_i,
  input  dcic_pkg::prio_ent_t                 ent_i,
  output dcic_pkg::prio_ent_t [NUM_SRC-1:0]   ent_q
);
  import dcic_pkg::*;

  for (genvar e = 0; e < NUM_SRC; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[e] <= '0;
      end else if (wr_i && (idx_i == IDX_W'(e))) begin
        ent_q[e] <= ent_i;
      end
    end
  end
endmodule

// File: rtl/dcic_prio_resolver.sv
module dcic_prio_resolver #(
  parameter int NUM_SRC = 40
) (
  input  dcic_pkg::prio_ent_t [NUM_SRC-1:0] ent_i,
  input  logic [NUM_SRC-1:0]                act_norm_i,
  input  logic [NUM_SRC-1:0]                act_fast_i,
  output logic [dcic_pkg::WORD_W-1:0]       hp_word_o
);
  import dcic_pkg::*;

  logic            norm_hit, fast_hit;
  logic [ID_W-1:0] norm_id, fast_id;

  // scan from the top entry down so the lowest index overwrites last
  always_comb begin
    norm_hit = 1'b0;
    fast_hit = 1'b0;
    norm_id  = '1;
    fast_id  = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (ent_i[i].vld && (int'(ent_i[i].id) < NUM_SRC)) begin
        if (act_fast_i[ent_i[i].id]) begin
          fast_hit = 1'b1;
          fast_id  = ent_i[i].id;
        end
        if (act_norm_i[ent_i[i].id]) begin
          norm_hit = 1'b1;
          norm_id  = ent_i[i].id;
        end
      end
    end
    hp_word_o = {norm_hit, 9'd0, norm_id, fast_hit, 9'd0, fast_id};
  end
endmodule

// File: rtl/dual_class_intc.sv
module dual_class_intc #(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl_i,
  input  logic               core_idle_i,
  input  logic               reg_wr_i,
  input  logic [7:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               wake_o
);
  import dcic_pkg::*;

  localparam int IDX_W  = $clog2(NUM_SRC);
  localparam int HI_CNT = NUM_SRC - WORD_W;

  logic [NUM_SRC-1:0] pend_q, en_q, cls_q, act_norm, act_fast;
  logic               ctrl_q;
  logic [NBANK-1:0]   en_we, cls_we;
  logic               aligned, bank_hit, bank_sel, prio_hit;
  logic [2:0]         view;
  logic [IDX_W-1:0]   prio_idx;
  logic [ADDR_W-1:0]  off_b1, off_lo, off_hi;
  logic [WORD_W-1:0]  hp_word;
  logic [WORD_W-1:0]  w_norm [NBANK];
  logic [WORD_W-1:0]  w_fast [NBANK];
  logic [WORD_W-1:0]  w_en   [NBANK];
  logic [WORD_W-1:0]  w_cls  [NBANK];
  logic [WORD_W-1:0]  w_raw  [NBANK];
  prio_ent_t [NUM_SRC-1:0] ent_q;
  prio_ent_t          ent_wr;

  // offset decode
  always_comb begin
    aligned  = (reg_addr_i[1:0] == 2'b00);
    off_b1   = reg_addr_i - OFS_BANK1;
    off_lo   = reg_addr_i - OFS_PRIO_LO;
    off_hi   = reg_addr_i - OFS_PRIO_HI;
    bank_hit = 1'b0;
    bank_sel = 1'b0;
    view     = 3'd0;
    prio_hit = 1'b0;
    prio_idx = '0;
    if (aligned && reg_addr_i <= OFS_RAW) begin
      bank_hit = 1'b1;
      view     = reg_addr_i[4:2];
    end else if (aligned && reg_addr_i >= OFS_BANK1 && off_b1 <= 8'h10) begin
      bank_hit = 1'b1;
      bank_sel = 1'b1;
      view     = off_b1[4:2];
    end
    if (aligned && reg_addr_i >= OFS_PRIO_LO && reg_addr_i <= OFS_PRIO_LE) begin
      prio_hit = 1'b1;
      prio_idx = IDX_W'(off_lo[7:2]);
    end else if (aligned && reg_addr_i >= OFS_PRIO_HI && int'(off_hi[7:2]) < HI_CNT) begin
      prio_hit = 1'b1;
      prio_idx = IDX_W'(WORD_W + int'(off_hi[7:2]));
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_we
    assign en_we[b]  = reg_wr_i && bank_hit && (bank_sel == b[0]) && (view == V_EN);
    assign cls_we[b] = reg_wr_i && bank_hit && (bank_sel == b[0]) && (view == V_CLS);
  end

  assign ent_wr.vld = reg_wdata_i[31];
  assign ent_wr.id  = reg_wdata_i[ID_W-1:0];

  dcic_src_state #(.NUM_SRC(NUM_SRC)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_lvl_i   (src_lvl_i),
    .core_idle_i (core_idle_i),
    .en_we_i     (en_we),
    .cls_we_i    (cls_we),
    .ctrl_we_i   (reg_wr_i && (reg_addr_i == OFS_CTRL)),
    .wdata_i     (reg_wdata_i),
    .pend_q      (pend_q),
    .en_q        (en_q),
    .cls_q       (cls_q),
    .ctrl_q      (ctrl_q),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o),
    .wake_o      (wake_o)
  );

  dcic_prio_table #(.NUM_SRC(NUM_SRC)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_i  (reg_wr_i && prio_hit),
    .idx_i (prio_idx),
    .ent_i (ent_wr),
    .ent_q (ent_q)
  );

  assign act_norm = pend_q & en_q & ~cls_q;
  assign act_fast = pend_q & en_q & cls_q;

  dcic_prio_resolver #(.NUM_SRC(NUM_SRC)) u_resolve (
    .ent_i      (ent_q),
    .act_norm_i (act_norm),
    .act_fast_i (act_fast),
    .hp_word_o  (hp_word)
  );

  // per-bank read words, unused bank bits stay zero
  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      w_norm[b] = '0;
      w_fast[b] = '0;
      w_en[b]   = '0;
      w_cls[b]  = '0;
      w_raw[b]  = '0;
      for (int j = 0; j < WORD_W; j++) begin
        if (b * WORD_W + j < NUM_SRC) begin
          w_norm[b][j] = act_norm[b * WORD_W + j];
          w_fast[b][j] = act_fast[b * WORD_W + j];
          w_en[b][j]   = en_q[b * WORD_W + j];
          w_cls[b][j]  = cls_q[b * WORD_W + j];
          w_raw[b][j]  = pend_q[b * WORD_W + j];
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (bank_hit) begin
      case (view)
        V_NORM:  reg_rdata_o = w_norm[bank_sel];
        V_EN:    reg_rdata_o = w_en[bank_sel];
        V_CLS:   reg_rdata_o = w_cls[bank_sel];
        V_FAST:  reg_rdata_o = w_fast[bank_sel];
        V_RAW:   reg_rdata_o = w_raw[bank_sel];
        default: reg_rdata_o = '0;
      endcase
    end else if (prio_hit) begin
      reg_rdata_o = {ent_q[prio_idx].vld, 25'd0, ent_q[prio_idx].id};
    end else if (reg_addr_i == OFS_CTRL) begin
      reg_rdata_o = {31'd0, ctrl_q};
    end else if (reg_addr_i == OFS_HIGH) begin
      reg_rdata_o = hp_word;
    end
  end

  // R3
  fiq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == (|(pend_q & en_q & cls_q)));

  // R4
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|(pend_q & en_q & ~cls_q)));

  // R9
  hp_norm_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hp_word[31] |-> (pend_q[hp_word[21:16]] && en_q[hp_word[21:16]] && !cls_q[hp_word[21:16]]));

  // R9
  hp_fast_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hp_word[15] |-> (pend_q[hp_word[5:0]] && en_q[hp_word[5:0]] && cls_q[hp_word[5:0]]));
endmodule

// File: tb/dual_class_intc_tb_top.sv
module dual_class_intc_tb_top;
  localparam int NS = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          idle = 1'b0;
  logic          wr = 1'b0;
  logic [7:0]    addr = 8'h00;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, fiq, wake;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit chk_en = 1'b0;

  always #4 clk = ~clk;

  dual_class_intc #(.NUM_SRC(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_lvl_i(src), .core_idle_i(idle),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
  );

  // behavioural reference
  logic [NS-1:0] m_pend, m_en, m_cls;
  logic          m_ctrl, m_irq, m_fiq, m_wake;
  logic [31:0]   m_prio [NS];

  function automatic int slot_of(input logic [7:0] a);
    if (a[1:0] != 0) return -1;
    if (a >= 8'h1C && a <= 8'h98) return (int'(a) - 28) / 4;
    if (a >= 8'hB0 && (int'(a) - 176) / 4 < NS - 32) return 32 + (int'(a) - 176) / 4;
    return -1;
  endfunction

  always @(posedge clk) begin
    logic [NS-1:0] ne, nc;
    logic nctl, any_i, any_f, any_w;
    if (!rst_n) begin
      m_pend <= '0; m_en <= '0; m_cls <= '0; m_ctrl <= 1'b0;
      m_irq <= 1'b0; m_fiq <= 1'b0; m_wake <= 1'b0;
      for (int i = 0; i < NS; i++) m_prio[i] <= '0;
    end else begin
      ne = m_en; nc = m_cls; nctl = m_ctrl;
      if (wr) begin
        for (int j = 0; j < 32; j++) begin
          if (addr == 8'h04 && j < NS) ne[j] = wdata[j];
          if (addr == 8'hA0 && j + 32 < NS) ne[j+32] = wdata[j];
          if (addr == 8'h08 && j < NS) nc[j] = wdata[j];
          if (addr == 8'hA4 && j + 32 < NS) nc[j+32] = wdata[j];
        end
        if (addr == 8'h14) nctl = wdata[0];
        if (slot_of(addr) >= 0) m_prio[slot_of(addr)] <= wdata & 32'h8000_003F;
      end
      any_i = 0; any_f = 0; any_w = 0;
      for (int j = 0; j < NS; j++) begin
        if (src[j] && ne[j] && !nc[j]) any_i = 1;
        if (src[j] && ne[j] && nc[j]) any_f = 1;
        if (src[j] && (ne[j] || !nctl)) any_w = 1;
      end
      m_pend <= src; m_en <= ne; m_cls <= nc; m_ctrl <= nctl;
      m_irq <= any_i; m_fiq <= any_f; m_wake <= any_w && idle;
    end
  end

  function automatic logic [31:0] model_hp();
    logic [31:0] r = 32'h003F_003F;
    bit got_n = 0, got_f = 0;
    for (int i = 0; i < NS; i++) begin
      int id = int'(m_prio[i][5:0]);
      if (m_prio[i][31] && id < NS && m_pend[id] && m_en[id]) begin
        if (!m_cls[id] && !got_n) begin got_n = 1; r[31:16] = 16'h8000 | 16'(id); end
        if (m_cls[id] && !got_f) begin got_f = 1; r[15:0] = 16'h8000 | 16'(id); end
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    int b = -1, v = 0;
    logic [31:0] r = '0;
    if (a[1:0] == 0 && a <= 8'h10) begin b = 0; v = int'(a) / 4; end
    else if (a[1:0] == 0 && a >= 8'h9C && a <= 8'hAC) begin b = 1; v = (int'(a) - 156) / 4; end
    if (b >= 0) begin
      for (int j = 0; j < 32; j++) begin
        int s = b * 32 + j;
        if (s < NS) begin
          case (v)
            0: r[j] = m_pend[s] & m_en[s] & ~m_cls[s];
            1: r[j] = m_en[s];
            2: r[j] = m_cls[s];
            3: r[j] = m_pend[s] & m_en[s] & m_cls[s];
            default: r[j] = m_pend[s];
          endcase
        end
      end
      return r;
    end
    if (a == 8'h14) return {31'd0, m_ctrl};
    if (a == 8'h18) return model_hp();
    if (slot_of(a) >= 0) return m_prio[slot_of(a)];
    return '0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a >= 8'h9C && a <= 8'hAC) return "R2";
    if (a <= 8'h10) return "R5";
    if (a == 8'h14) return "R6";
    if (a == 8'h18) return "R9";
    if (slot_of(a) >= 0) return "R8";
    return "R11";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare with the reference on every cycle, away from the edge
  always @(negedge clk) begin
    if (chk_en) begin
      check("R4", {31'd0, irq}, {31'd0, m_irq});
      check("R3", {31'd0, fiq}, {31'd0, m_fiq});
      check("R7", {31'd0, wake}, {31'd0, m_wake});
      check(tag_of(addr), rdata, model_rd(addr));
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic rd_expect(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    check(req, rdata, exp);
  endtask

  task automatic out_expect(input string req, input logic i, input logic f, input logic w);
    @(posedge clk);
    @(negedge clk);
    check(req, {29'd0, irq, fiq, wake}, {29'd0, i, f, w});
  endtask

  task automatic set_in(input int bit_no, input logic val);
    @(posedge clk); #1;
    src[bit_no] = val;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    logic [7:0] pick [16];
    pick = '{8'h04, 8'hA0, 8'h08, 8'hA4, 8'h14, 8'h1C, 8'h20, 8'h24,
             8'hB0, 8'hCC, 8'h00, 8'hD0, 8'h05, 8'h18, 8'h10, 8'hAC};
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_en = 1'b1;

    // R10 reset state
    out_expect("R10", 1'b0, 1'b0, 1'b0);
    rd_expect("R10", 8'h04, 32'h0);
    rd_expect("R10", 8'h08, 32'h0);
    rd_expect("R10", 8'h10, 32'h0);
    rd_expect("R10", 8'h14, 32'h0);
    rd_expect("R10", 8'h1C, 32'h0);
    rd_expect("R9", 8'h18, 32'h003F_003F);

    // R1 raw pending follows the line, masked source gives no output
    set_in(3, 1'b1);
    rd_expect("R1", 8'h10, 32'h8);
    out_expect("R4", 1'b0, 1'b0, 1'b0);
    wr_reg(8'h04, 32'h8);
    out_expect("R4", 1'b1, 1'b0, 1'b0);
    rd_expect("R5", 8'h00, 32'h8);
    rd_expect("R5", 8'h0C, 32'h0);
    wr_reg(8'h08, 32'h8);
    out_expect("R3", 1'b0, 1'b1, 1'b0);
    rd_expect("R5", 8'h0C, 32'h8);
    rd_expect("R5", 8'h00, 32'h0);

    // R2 bank 1
    set_in(35, 1'b1);
    wr_reg(8'hA0, 32'h8);
    out_expect("R2", 1'b1, 1'b1, 1'b0);
    rd_expect("R2", 8'h9C, 32'h8);
    rd_expect("R2", 8'hAC, 32'h8);
    wr_reg(8'hA0, 32'hFFFF_FFFF);
    rd_expect("R2", 8'hA0, 32'h0000_00FF);

    // R8 / R9 priority table
    wr_reg(8'h1C, 32'hFFFF_FFFF);
    rd_expect("R8", 8'h1C, 32'h8000_003F);
    rd_expect("R9", 8'h18, 32'h003F_003F);
    wr_reg(8'h20, 32'h8000_0023);
    wr_reg(8'h24, 32'h8000_0003);
    rd_expect("R9", 8'h18, 32'h8023_8003);
    wr_reg(8'hB0, 32'h7FFF_FFE3);
    rd_expect("R8", 8'hB0, 32'h0000_0023);
    wr_reg(8'hCC, 32'h8000_0024);
    rd_expect("R8", 8'hCC, 32'h8000_0024);
    set_in(36, 1'b1);
    wr_reg(8'h28, 32'h8000_0024);
    rd_expect("R9", 8'h18, 32'h8023_8003);
    wr_reg(8'h20, 32'h0);
    rd_expect("R9", 8'h18, 32'h8024_8003);

    // R1 level drop clears pending at once
    set_in(3, 1'b0);
    rd_expect("R1", 8'h10, 32'h0);
    out_expect("R3", 1'b1, 1'b0, 1'b0);
    set_in(3, 1'b1);

    // R11 ignored writes and empty reads
    wr_reg(8'h00, 32'hFFFF_FFFF);
    wr_reg(8'h05, 32'h0);
    wr_reg(8'h10, 32'h0);
    wr_reg(8'hD0, 32'hFFFF_FFFF);
    rd_expect("R11", 8'h04, 32'h8);
    rd_expect("R11", 8'h08, 32'h8);
    rd_expect("R11", 8'h10, 32'h8);
    rd_expect("R11", 8'hD0, 32'h0);
    rd_expect("R11", 8'h06, 32'h0);

    // R6 / R7 wake control
    @(posedge clk); #1 idle = 1'b1;
    out_expect("R7", 1'b1, 1'b1, 1'b1);
    wr_reg(8'h04, 32'h0);
    wr_reg(8'hA0, 32'h0);
    out_expect("R6", 1'b0, 1'b0, 1'b1);
    wr_reg(8'h14, 32'hFFFF_FFFF);
    rd_expect("R6", 8'h14, 32'h1);
    out_expect("R6", 1'b0, 1'b0, 1'b0);
    wr_reg(8'h04, 32'h8);
    out_expect("R7", 1'b0, 1'b1, 1'b1);
    @(posedge clk); #1 idle = 1'b0;
    out_expect("R7", 1'b0, 1'b1, 1'b0);

    // mixed traffic against the reference
    lf = 32'h1D2C_3B4A;
    for (int c = 0; c < 3000; c++) begin
      @(posedge clk); #1;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      src  = {lf[15:8], lf} & {8'hFF, lf[31:24], lf[7:0], lf[23:16], lf[31:24]};
      idle = lf[5];
      addr = pick[lf[19:16]];
      wr   = (lf[27:26] == 2'b00);
      wdata = {lf[3:0], lf[31:4]} ^ {2{lf[31:16]}};
    end
    @(posedge clk); #1 wr = 1'b0;
    @(negedge clk);

    done = 1'b1;
    chk_en = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule